// File: doc/BRIEF.md
# Dual Programmable Down-Counter Timer

This peripheral holds two independent down-counter channels behind a small byte-wide register bus. Each channel has a reload value, a live counter and an 8-bit control byte. The control byte selects one of five behaviours: a latching timeout, a single strobe, a retriggerable one-shot started by a gate edge, a periodic rate pulse, or a waveform whose high and low lengths are programmed separately. Counting advances on a per-channel tick input. This input is a one-cycle enable that is synchronous to the system clock. A per-channel gate input, whose active level is programmable, qualifies the counting or retriggers it.

Each channel drives a true output and a complemented output. When a channel expires it sets a sticky flag in a shared status byte. One active-low interrupt line is asserted while any flag whose channel has interrupts enabled is set. Reading the status byte returns the flags and clears them.

The host writes reload bytes and control bytes, then starts a channel by setting its run bit. It can read the live count at any time. It can also set a hold bit so that the two count bytes stay frozen while it reads them one at a time.

Top module: `dual_ctmr`

## Requirements
- R1: Address map on `addr`: 0 = channel A count high byte, 1 = A low byte, 2 = B high byte, 3 = B low byte, 4 = A control, 5 = B control, 6 = status, 7 reads 0. A write to 0..3 sets the reload byte. A read of 0..3 returns the counter view. Control bytes read back as written.
- R2: Control byte fields: bits 2:0 = mode, bit 3 = gate polarity, bit 4 = run, bit 5 = interrupt enable, bit 6 = hold. A 0-to-1 change of run reloads the counter from the reload value, one cycle after the write. Clearing run freezes the counter. Mode codes 0, 6 and 7 never decrement and keep the output low.
- R3: In modes 1, 2, 4 and 5 a tick decrements only while the gate is at its active level: high when the polarity bit is 1, low when it is 0.
- R4: Mode 1: the output is low while counting. On the tick that takes the counter from 1 to 0 the output goes high and stays high until the next start. A counter at 0 does not decrement.
- R5: Mode 2: on the tick that takes the counter from 1 to 0 the output is high for exactly one system clock cycle, then low.
- R6: Mode 3: ticks are not gated. A change of the gate to its active level while the counter is nonzero reloads the counter and drives the output low. The output goes high on reaching 0. A gate edge after expiry has no effect.
- R7: Mode 4: on a gated tick with the counter at 1 or below, the counter reloads, the output pulses high for one cycle and the flag is set. The period is the reload value in ticks.
- R8: Mode 5: the reload high byte sets the high-phase length and the low byte sets the low-phase length, both in ticks. Start enters the high phase. The flag is set each time a low phase ends.
- R9: `out_c` is always the complement of `out_t`.
- R10: Expiry sets status bit 0 (channel A) or bit 1 (channel B) regardless of interrupt enable. A read of address 6 returns the flags and clears them. A flag set in that same cycle is kept.
- R11: `irq_n` is low exactly while some status flag is set whose channel has its interrupt enable bit at 1.
- R12: While the hold bit is 1, reads of a channel's count bytes return the value the counter had when hold was written, while the counter keeps running.
- R13: After reset all control bytes, reload values, counters and flags are 0, both true outputs are low and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, qualified by cs |
| wr | input | 1 | Write strobe, qualified by cs |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (0 when not reading) |
| tick | input | 2 | Per-channel count enables (bit 0 = A) |
| gate | input | 2 | Per-channel gate inputs |
| out_t | output | 2 | True outputs |
| out_c | output | 2 | Complemented outputs |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
A vector table runs each mode with tick counts that stop short of expiry, stop exactly on it and pass beyond it. This separates a counter that is off by one from one that fails to latch, fails to reload or fails to flip phase. The gating vectors repeat one count with the gate held active, held inactive and with polarity inverted, so a reversed polarity bit shows up. The directed tests cover retriggering before and after expiry, stopping and restarting, an illegal mode code, a hold that is set while ticks continue, both channels expiring on the same edge, and expiry with interrupts disabled. These cases separate the status flags from the interrupt line.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int NCH = 2;

    localparam logic [2:0] M_OFF     = 3'd0;
    localparam logic [2:0] M_TIMEOUT = 3'd1;
    localparam logic [2:0] M_STROBE  = 3'd2;
    localparam logic [2:0] M_ONESHOT = 3'd3;
    localparam logic [2:0] M_RATE    = 3'd4;
    localparam logic [2:0] M_DUTY    = 3'd5;

    typedef struct packed {
        logic       spare;
        logic       hold;
        logic       ien;
        logic       run;
        logic       gpol;
        logic [2:0] mode;
    } ctl_t;

endpackage

// File: rtl/ctmr_chan.sv
module ctmr_chan
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  logic [CNT_W-1:0] preset,
    input  logic             tick,
    input  logic             gate,
    output logic [CNT_W-1:0] view,
    output logic             out,
    output logic             expire
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             out;
        logic             ph;
        logic             run_prev;
        logic             gprev;
    } st_t;

    st_t st_d, st_q;
    logic gact;
    logic mode_ok;
    logic [CNT_W-1:0] hi_len, lo_len;

    always_comb begin
        st_d    = st_q;
        expire  = 1'b0;
        gact    = ctl.gpol ? gate : ~gate;
        mode_ok = (ctl.mode >= M_TIMEOUT) && (ctl.mode <= M_DUTY);
        hi_len  = {{(CNT_W-HALF){1'b0}}, preset[CNT_W-1:HALF]};
        lo_len  = {{(CNT_W-HALF){1'b0}}, preset[HALF-1:0]};

        st_d.run_prev = ctl.run;
        st_d.gprev    = gact;
        st_d.snap     = ctl.hold ? st_q.snap : st_q.cnt;

        if (ctl.mode == M_STROBE || ctl.mode == M_RATE || !mode_ok)
            st_d.out = 1'b0;

        if (ctl.run && !st_q.run_prev) begin
            st_d.ph = 1'b1;
            if (ctl.mode == M_DUTY) begin
                st_d.cnt = hi_len;
                st_d.out = 1'b1;
            end else begin
                st_d.cnt = preset;
                st_d.out = 1'b0;
            end
        end else if (ctl.run && mode_ok) begin
            case (ctl.mode)
                M_TIMEOUT, M_STROBE: begin
                    if (tick && gact && st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - ONE;
                        if (st_q.cnt == ONE) begin
                            expire   = 1'b1;
                            st_d.out = 1'b1;
                        end
                    end
                end
                M_ONESHOT: begin
                    if (gact && !st_q.gprev && st_q.cnt != '0) begin
                        st_d.cnt = preset;
                        st_d.out = 1'b0;
                    end else if (tick && st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - ONE;
                        if (st_q.cnt == ONE) begin
                            expire   = 1'b1;
                            st_d.out = 1'b1;
                        end
                    end
                end
                M_RATE: begin
                    if (tick && gact) begin
                        if (st_q.cnt <= ONE) begin
                            st_d.cnt = preset;
                            st_d.out = 1'b1;
                            expire   = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
                M_DUTY: begin
                    if (tick && gact) begin
                        if (st_q.cnt <= ONE) begin
                            st_d.ph  = ~st_q.ph;
                            st_d.out = ~st_q.ph;
                            st_d.cnt = st_q.ph ? lo_len : hi_len;
                            expire   = ~st_q.ph;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign view = ctl.hold ? st_q.snap : st_q.cnt;
    assign out  = st_q.out;

endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs,
    input  logic                       rd,
    input  logic                       wr,
    input  logic [2:0]                 addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NCH-1:0][CNT_W-1:0]  views,
    input  logic [NCH-1:0]             expire,
    output ctl_t [NCH-1:0]             ctl,
    output logic [NCH-1:0][CNT_W-1:0]  presets,
    output logic [NCH-1:0]             flags,
    output logic                       irq_n
);
    typedef struct packed {
        ctl_t [NCH-1:0]              ctl;
        logic [NCH-1:0][CNT_W-1:0]   pre;
        logic [NCH-1:0]              flg;
    } rg_t;

    rg_t rg_d, rg_q;
    logic wr_en, rd_en, rd_stat;
    logic [NCH-1:0] ien_vec;

    always_comb begin
        rg_d    = rg_q;
        wr_en   = cs && wr;
        rd_en   = cs && rd && !wr;
        rd_stat = rd_en && (addr == 3'd6);

        if (wr_en) begin
            if (!addr[2]) begin
                if (addr[0]) rg_d.pre[addr[1]][DATA_W-1:0]     = wdata;
                else         rg_d.pre[addr[1]][CNT_W-1:DATA_W] = wdata;
            end else if (!addr[1]) begin
                rg_d.ctl[addr[0]] = ctl_t'(wdata[7:0]);
            end
        end

        rg_d.flg = expire | (rg_q.flg & {NCH{~rd_stat}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (!addr[2]) begin
                if (addr[0]) rdata = views[addr[1]][DATA_W-1:0];
                else         rdata = views[addr[1]][CNT_W-1:DATA_W];
            end else if (!addr[1]) begin
                rdata = DATA_W'(rg_q.ctl[addr[0]]);
            end else if (!addr[0]) begin
                rdata = DATA_W'(rg_q.flg);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) ien_vec[i] = rg_q.ctl[i].ien;
    end

    assign ctl     = rg_q.ctl;
    assign presets = rg_q.pre;
    assign flags   = rg_q.flg;
    assign irq_n   = ~|(rg_q.flg & ien_vec);

endmodule

// File: rtl/dual_ctmr.sv
module dual_ctmr
    import ctmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [1:0]        tick,
    input  logic [1:0]        gate,
    output logic [1:0]        out_t,
    output logic [1:0]        out_c,
    output logic              irq_n
);
    localparam int CNT_W = 2 * DATA_W;

    ctl_t [NCH-1:0]             ctl_w;
    logic [NCH-1:0][CNT_W-1:0]  pre_w;
    logic [NCH-1:0][CNT_W-1:0]  view_w;
    logic [NCH-1:0]             exp_w;
    logic [NCH-1:0]             flag_w;

    ctmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .rd      (rd),
        .wr      (wr),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .views   (view_w),
        .expire  (exp_w),
        .ctl     (ctl_w),
        .presets (pre_w),
        .flags   (flag_w),
        .irq_n   (irq_n)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ctmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl_w[g]),
            .preset (pre_w[g]),
            .tick   (tick[g]),
            .gate   (gate[g]),
            .view   (view_w[g]),
            .out    (out_t[g]),
            .expire (exp_w[g])
        );
    end

    assign out_c = ~out_t;

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             rd,
    input logic             wr,
    input logic [2:0]       addr,
    input logic             irq_n,
    input logic [1:0]       out_t,
    input logic [1:0]       exp_w,
    input logic [1:0]       flag_w,
    input ctl_t             ctl0,
    input logic [CNT_W-1:0] view0
);
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_w[0] |=> flag_w[0]);

    // R11
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr && addr == 3'd6 && exp_w == 2'b00) |=> irq_n);

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0.mode == 3'd2 && out_t[0]) |=> !out_t[0]);

    // R4
    timeout_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0.mode == 3'd1 && ctl0.run && out_t[0] && $stable(ctl0)) |=> out_t[0]);

    // R12
    hold_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0.hold && $past(ctl0.hold)) |-> $stable(view0));

endmodule

bind dual_ctmr ctmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .rd     (rd),
    .wr     (wr),
    .addr   (addr),
    .irq_n  (irq_n),
    .out_t  (out_t),
    .exp_w  (exp_w),
    .flag_w (flag_w),
    .ctl0   (ctl_w[0]),
    .view0  (view_w[0])
);

// File: tb/dual_ctmr_test.sv
`timescale 1ns/1ps
module dual_ctmr_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] tick = 2'b00, gate = 2'b00;
    logic [1:0] out_t, out_c;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;

    dual_ctmr uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate),
        .out_t(out_t), .out_c(out_c), .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic        ch;
        logic [2:0]  mode;
        logic        gpol;
        logic        gate;
        logic [15:0] pre;
        logic [3:0]  nt;
        logic        xout;
        logic [15:0] xcnt;
        logic [1:0]  xstat;
    } vec_t;

    // rows 2 and 3 exercise gating and polarity (R3)
    localparam vec_t VEC [12] = '{
        '{1'b0, 3'd1, 1'b1, 1'b1, 16'd5,     4'd3, 1'b0, 16'd2,     2'b00},
        '{1'b0, 3'd1, 1'b1, 1'b1, 16'd5,     4'd5, 1'b1, 16'd0,     2'b01},
        '{1'b0, 3'd1, 1'b1, 1'b0, 16'd5,     4'd4, 1'b0, 16'd5,     2'b00},
        '{1'b0, 3'd1, 1'b0, 1'b0, 16'd5,     4'd5, 1'b1, 16'd0,     2'b01},
        '{1'b1, 3'd1, 1'b1, 1'b1, 16'h0102,  4'd2, 1'b0, 16'h0100,  2'b00},
        '{1'b1, 3'd4, 1'b1, 1'b1, 16'd3,     4'd7, 1'b0, 16'd2,     2'b10},
        '{1'b1, 3'd2, 1'b1, 1'b1, 16'd2,     4'd2, 1'b1, 16'd0,     2'b10},
        '{1'b1, 3'd2, 1'b1, 1'b1, 16'd2,     4'd1, 1'b0, 16'd1,     2'b00},
        '{1'b0, 3'd5, 1'b1, 1'b1, 16'h0203,  4'd1, 1'b1, 16'd1,     2'b00},
        '{1'b0, 3'd5, 1'b1, 1'b1, 16'h0203,  4'd2, 1'b0, 16'd3,     2'b00},
        '{1'b0, 3'd5, 1'b1, 1'b1, 16'h0203,  4'd5, 1'b1, 16'd2,     2'b01},
        '{1'b0, 3'd3, 1'b1, 1'b0, 16'd4,     4'd4, 1'b1, 16'd0,     2'b01}
    };

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic ticks(input logic [1:0] which, input int n);
        for (int i = 0; i < n; i++) begin
            tick = which;
            @(negedge clk);
        end
        tick = 2'b00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_cnt(input logic ch, output logic [15:0] v);
        logic [7:0] h, l;
        bus_rd({1'b0, ch, 1'b0}, h);
        bus_rd({1'b0, ch, 1'b1}, l);
        v = {h, l};
    endtask

    // start a channel: control byte with run clear, reload bytes, then run set
    task automatic start_ch(input logic ch, input logic [15:0] pre, input logic [7:0] c);
        bus_wr({2'b10, ch}, c & 8'hEF);
        bus_wr({1'b0, ch, 1'b0}, pre[15:8]);
        bus_wr({1'b0, ch, 1'b1}, pre[7:0]);
        bus_wr({2'b10, ch}, c | 8'h10);
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R13 reset state
        check("R13 out_t", out_t, 0);
        check("R13 out_c R9", out_c, 3);
        check("R13 irq_n", irq_n, 1);
        bus_rd(3'd4, d); check("R13 ctl A", d, 0);
        bus_rd(3'd6, d); check("R13 status", d, 0);
        read_cnt(1'b1, v); check("R13 count B", v, 0);

        // vector walk
        for (int k = 0; k < 12; k++) begin
            gate = 2'b00;
            gate[VEC[k].ch] = VEC[k].gate;
            start_ch(VEC[k].ch, VEC[k].pre,
                     {2'b00, 1'b1, 1'b0, VEC[k].gpol, VEC[k].mode});
            ticks(VEC[k].ch ? 2'b10 : 2'b01, int'(VEC[k].nt));
            check({mode_tag(VEC[k].mode), " out"}, out_t[VEC[k].ch], VEC[k].xout);
            check("R9 out_c", out_c[VEC[k].ch], !VEC[k].xout);
            read_cnt(VEC[k].ch, v);
            check({mode_tag(VEC[k].mode), " count"}, v, VEC[k].xcnt);
            bus_rd(3'd6, d);
            check("R10 status", d, VEC[k].xstat);
        end

        // R6 retrigger before and after expiry
        gate = 2'b00;
        start_ch(1'b0, 16'd4, 8'h2B);
        ticks(2'b01, 2);
        gate[0] = 1'b1; idle(1);
        read_cnt(1'b0, v); check("R6 retrigger reload", v, 4);
        ticks(2'b01, 3);
        check("R6 out before zero", out_t[0], 0);
        ticks(2'b01, 1);
        check("R6 out at zero", out_t[0], 1);
        gate[0] = 1'b0; idle(1); gate[0] = 1'b1; idle(1);
        read_cnt(1'b0, v); check("R6 late edge ignored", v, 0);
        check("R6 out kept", out_t[0], 1);
        bus_rd(3'd6, d);

        // R12 hold
        gate = 2'b01;
        start_ch(1'b0, 16'd10, 8'h29);
        ticks(2'b01, 2);
        bus_wr(3'd4, 8'h79);
        ticks(2'b01, 3);
        read_cnt(1'b0, v); check("R12 held view", v, 8);
        bus_wr(3'd4, 8'h39);
        read_cnt(1'b0, v); check("R12 live after release", v, 5);
        bus_rd(3'd4, d); check("R1 control readback", d, 8'h39);

        // R2 stop, restart, illegal mode
        gate = 2'b10;
        start_ch(1'b1, 16'd6, 8'h29);
        ticks(2'b10, 2);
        bus_wr(3'd5, 8'h29);
        ticks(2'b10, 2);
        read_cnt(1'b1, v); check("R2 frozen when stopped", v, 4);
        bus_wr(3'd5, 8'h39); idle(2);
        read_cnt(1'b1, v); check("R2 reload on start", v, 6);
        start_ch(1'b1, 16'd6, 8'h2E);
        ticks(2'b10, 3);
        read_cnt(1'b1, v); check("R2 illegal mode holds", v, 6);
        check("R2 illegal mode output", out_t[1], 0);

        // R11 interrupt disabled but flag set
        start_ch(1'b1, 16'd1, 8'h09);
        ticks(2'b10, 1);
        check("R11 irq masked", irq_n, 1);
        bus_rd(3'd6, d); check("R10 flag without enable", d, 2);

        // R10 R11 both channels on one edge
        gate = 2'b11;
        start_ch(1'b0, 16'd1, 8'h29);
        start_ch(1'b1, 16'd1, 8'h29);
        ticks(2'b11, 1);
        check("R11 irq asserted", irq_n, 0);
        bus_rd(3'd6, d); check("R10 both flags", d, 3);
        check("R11 irq after clear", irq_n, 1);
        bus_rd(3'd6, d); check("R10 cleared", d, 0);

        // R1 reserved location
        bus_rd(3'd7, d); check("R1 reserved reads zero", d, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule